// File: doc/BRIEF.md
# Predicated Vector Shift-and-Insert Unit

This block performs a lane-wise shift-and-insert on a 128-bit vector. Every element of a source vector is shifted by an immediate count, either toward the least significant end (right insert) or toward the most significant end (left insert). Only the bit positions that the shifted source value covers are written into the matching element of the destination vector. All other destination bits are kept. Elements may be 8, 16 or 32 bits wide. A 16-bit byte predicate decides which destination bytes may change at all.

One operation is presented per cycle with `in_valid`. The result is registered and appears one cycle later, together with a one-cycle `done` pulse and a one-cycle predicate-advance strobe. Illegal combinations of opcode, element size and count raise `err` and return the destination untouched. The two edge counts, 0 for left insert and the element width for right insert, are legal, cause no change and raise no error.

The control is a two-state machine. `ST_IDLE` moves to `ST_EMIT` when `in_valid` is high (transition *accept*). `ST_EMIT` stays in `ST_EMIT` when another `in_valid` arrives (transition *chain*) and returns to `ST_IDLE` otherwise (transition *retire*). `ST_IDLE` stays in `ST_IDLE` while no operation arrives (transition *wait*). `done` and `pred_adv` are high exactly while the machine is in `ST_EMIT`.

Top module: `vec_shift_insert`

## Requirements
- R1: While `rst_n` is low and after reset, `done`, `pred_adv` and `err` are 0 and `res_vec` is all zeros until the first operation completes.
- R2: Each cycle with `in_valid` high produces `done` high in the next cycle, and only then, so back-to-back operations give back-to-back pulses. `res_vec` holds its value in cycles without an operation.
- R3: With opcode 4'b0100 (right insert) and count s, the bits 0 to E-s-1 of each E-bit element become source>>s, and bits E-s to E-1 keep the destination.
- R4: With opcode 4'b0101 (left insert) and count s, the bits s to E-1 of each element become source<<s, and bits 0 to s-1 keep the destination.
- R5: `elem_size` encodes the element width E as 2'b00 = 8, 2'b01 = 16 and 2'b10 = 32. Shifted bits never cross from one element into its neighbour.
- R6: A right insert with s = E, or a left insert with s = 0, returns the destination unchanged with `err` low.
- R7: Bit b of `pred_mask` governs byte b (`res_vec[8b+7:8b]`). Bits 0 to 7 cover the lower 64-bit half and bits 8 to 15 cover the upper half. A byte whose bit is 0 keeps its destination value.
- R8: `err` goes high with `done`, and the destination is returned unchanged, for any of these inputs: `elem_size` 2'b11, any other opcode, a right count of 0 or greater than E, or a left count of E or more.
- R9: `pred_adv` pulses for exactly one cycle together with `done` after every operation, including the no-change and error cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 4 | 4'b0100 right insert, 4'b0101 left insert |
| elem_size | input | 2 | Element width code |
| shift_amt | input | 6 | Immediate shift count |
| pred_mask | input | 16 | Per-byte write predicate |
| dst_vec | input | 128 | Destination (old) vector |
| src_vec | input | 128 | Source vector to shift |
| res_vec | output | 128 | Registered result |
| done | output | 1 | One-cycle completion pulse |
| pred_adv | output | 1 | One-cycle predicate-advance strobe |
| err | output | 1 | Illegal operation flag, valid with done |

## Verification
The bench aims at the count boundaries: s = E for right insert and s = 0 for left insert must give an unchanged destination. A design that fed these counts to the generic shift would clear or overwrite whole elements. The bench also tries s = 0 right and s = E left, which must raise `err`; a design that accepted them would silently write. It uses alternating-bit patterns at every element size so that a bit leaking across an element boundary shows up. It also uses sparse predicates, including ones that split a wide element, so that a predicate applied per element or per half would rewrite protected bytes. Back-to-back and gapped strobes catch a `done` or `pred_adv` pulse that is stretched or dropped.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
    localparam int SHW = 6;
    typedef logic [SHW-1:0] shamt_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } esz_e;

    localparam logic [3:0] OPC_INS_RIGHT = 4'b0100;
    localparam logic [3:0] OPC_INS_LEFT  = 4'b0101;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } vsi_state_e;

    function automatic shamt_t elem_bits(input esz_e sz);
        unique case (sz)
            SZ_BYTE: elem_bits = shamt_t'(8);
            SZ_HALF: elem_bits = shamt_t'(16);
            SZ_WORD: elem_bits = shamt_t'(32);
            default: elem_bits = shamt_t'(0);
        endcase
    endfunction
endpackage

// File: rtl/vsi_op_decode.sv
module vsi_op_decode
    import vsi_pkg::*;
(
    input  logic [3:0] op_code,
    input  esz_e       size,
    input  shamt_t     shamt,
    output logic       is_left,
    output logic       legal,
    output logic       pass_thru
);
    shamt_t ebits;
    logic   op_ok;
    logic   size_ok;
    logic   range_ok;

    always_comb begin
        ebits    = elem_bits(size);
        is_left  = (op_code == OPC_INS_LEFT);
        op_ok    = (op_code == OPC_INS_LEFT) || (op_code == OPC_INS_RIGHT);
        size_ok  = (size != SZ_RSVD);
        if (is_left) begin
            range_ok = (shamt < ebits);
        end else begin
            range_ok = (shamt != '0) && (shamt <= ebits);
        end
        legal     = op_ok && size_ok && range_ok;
        pass_thru = legal && ((shamt == '0) || (shamt == ebits));
    end
endmodule

// File: rtl/vsi_lane_unit.sv
module vsi_lane_unit
    import vsi_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [EW-1:0] dst_l,
    input  logic [EW-1:0] src_l,
    input  logic          is_left,
    input  shamt_t        shamt,
    output logic [EW-1:0] out_l
);
    localparam logic [EW-1:0] ONES = {EW{1'b1}};

    logic [EW-1:0] shifted;
    logic [EW-1:0] fill_mask;

    always_comb begin
        if (is_left) begin
            shifted   = src_l << shamt;
            fill_mask = ONES << shamt;
        end else begin
            shifted   = src_l >> shamt;
            fill_mask = ONES >> shamt;
        end
        out_l = (shifted & fill_mask) | (dst_l & ~fill_mask);
    end
endmodule

// File: rtl/vsi_half_unit.sv
module vsi_half_unit
    import vsi_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic [HALF_W-1:0] dst_h,
    input  logic [HALF_W-1:0] src_h,
    input  esz_e              size,
    input  logic              is_left,
    input  shamt_t            shamt,
    output logic [HALF_W-1:0] out_h
);
    localparam int NUM_SZ = 3;

    logic [HALF_W-1:0] cand [NUM_SZ];

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
        localparam int EW = 8 << k;
        localparam int NL = HALF_W / EW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            vsi_lane_unit #(.EW(EW)) i_lane (
                .dst_l   (dst_h[l*EW +: EW]),
                .src_l   (src_h[l*EW +: EW]),
                .is_left (is_left),
                .shamt   (shamt),
                .out_l   (cand[k][l*EW +: EW])
            );
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: out_h = cand[0];
            SZ_HALF: out_h = cand[1];
            SZ_WORD: out_h = cand[2];
            default: out_h = dst_h;
        endcase
    end
endmodule

// File: rtl/vec_shift_insert.sv
module vec_shift_insert
    import vsi_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int HALF_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           op_code,
    input  logic [1:0]           elem_size,
    input  logic [SHW-1:0]       shift_amt,
    input  logic [VEC_W/8-1:0]   pred_mask,
    input  logic [VEC_W-1:0]     dst_vec,
    input  logic [VEC_W-1:0]     src_vec,
    output logic [VEC_W-1:0]     res_vec,
    output logic                 done,
    output logic                 pred_adv,
    output logic                 err
);
    localparam int NUM_HALF = VEC_W / HALF_W;
    localparam int NUM_BYTE = VEC_W / 8;

    vsi_state_e       state_q, state_d;
    logic             is_left, legal, pass_thru, wr_ok;
    logic [VEC_W-1:0] calc_vec, next_res, res_q;
    logic             err_q;
    esz_e             size;

    assign size = esz_e'(elem_size);

    vsi_op_decode i_decode (
        .op_code   (op_code),
        .size      (size),
        .shamt     (shift_amt),
        .is_left   (is_left),
        .legal     (legal),
        .pass_thru (pass_thru)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        vsi_half_unit #(.HALF_W(HALF_W)) i_half (
            .dst_h   (dst_vec[h*HALF_W +: HALF_W]),
            .src_h   (src_vec[h*HALF_W +: HALF_W]),
            .size    (size),
            .is_left (is_left),
            .shamt   (shift_amt),
            .out_h   (calc_vec[h*HALF_W +: HALF_W])
        );
    end

    assign wr_ok = legal && !pass_thru;

    for (genvar b = 0; b < NUM_BYTE; b++) begin : g_byte
        assign next_res[b*8 +: 8] = (wr_ok && pred_mask[b]) ? calc_vec[b*8 +: 8]
                                                             : dst_vec[b*8 +: 8];
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= in_valid && !legal;
            if (in_valid) begin
                res_q <= next_res;
            end
        end
    end

    assign res_vec  = res_q;
    assign err      = err_q;
    assign done     = (state_q == ST_EMIT);
    assign pred_adv = (state_q == ST_EMIT);
endmodule

// File: rtl/vsi_checker.sv
module vsi_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op_code,
    input logic [1:0]   elem_size,
    input logic [5:0]   shift_amt,
    input logic [15:0]  pred_mask,
    input logic [127:0] dst_vec,
    input logic [127:0] res_vec,
    input logic         done,
    input logic         pred_adv,
    input logic         err
);
    p_done_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    p_adv_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done == pred_adv);

    p_err_only_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_rsvd_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_size == 2'b11) |=> (err && res_vec == $past(dst_vec)));

    p_left_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'b0101 && shift_amt == 6'd0 && elem_size != 2'b11)
        |=> (!err && res_vec == $past(dst_vec)));

    p_pred_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_mask == 16'h0) |=> (res_vec == $past(dst_vec)));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_vec));
endmodule

bind vec_shift_insert vsi_checker i_vsi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .elem_size (elem_size),
    .shift_amt (shift_amt),
    .pred_mask (pred_mask),
    .dst_vec   (dst_vec),
    .res_vec   (res_vec),
    .done      (done),
    .pred_adv  (pred_adv),
    .err       (err)
);

// File: tb/test_vec_shift_insert.sv
`timescale 1ns/1ps
module test_vec_shift_insert;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op_code = 4'h0;
    logic [1:0]   elem_size = 2'b00;
    logic [5:0]   shift_amt = 6'd0;
    logic [15:0]  pred_mask = 16'h0;
    logic [127:0] dst_vec = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] res_vec;
    logic         done, pred_adv, err;

    int tests = 0;
    int fails = 0;

    logic [127:0] exp_res = '0;
    logic         exp_done = 1'b0;
    logic         exp_err = 1'b0;

    always #5 clk = ~clk;

    vec_shift_insert i_vec_shift_insert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .elem_size(elem_size), .shift_amt(shift_amt), .pred_mask(pred_mask),
        .dst_vec(dst_vec), .src_vec(src_vec), .res_vec(res_vec),
        .done(done), .pred_adv(pred_adv), .err(err)
    );

    // Behavioural reference, bit by bit over the whole vector
    task automatic ref_op(input logic [3:0] op, input logic [1:0] sz, input int s,
                          input logic [15:0] pm, input logic [127:0] d,
                          input logic [127:0] sv, output logic [127:0] r,
                          output logic e);
        int  ew;
        bit  left, ok, nochange;
        r    = d;
        ew   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : (sz == 2'b10) ? 32 : 0;
        left = (op == 4'b0101);
        ok   = (ew != 0) && (op == 4'b0101 || op == 4'b0100);
        if (ok) ok = left ? (s < ew) : (s >= 1 && s <= ew);
        e    = !ok;
        nochange = ok && (s == 0 || s == ew);
        if (ok && !nochange) begin
            for (int p = 0; p < 128; p++) begin
                int i;
                i = p % ew;
                if (pm[p/8]) begin
                    if (left && i >= s)             r[p] = sv[p - s];
                    else if (!left && i <= ew-s-1)  r[p] = sv[p + s];
                end
            end
        end
    endtask

    task automatic check(input string tag);
        tests++;
        if (res_vec !== exp_res || done !== exp_done || pred_adv !== exp_done
            || err !== exp_err) begin
            fails++;
            $display("FAIL %s res=%h exp=%h done=%b exp=%b adv=%b exp=%b err=%b exp=%b",
                     tag, res_vec, exp_res, done, exp_done, pred_adv, exp_done,
                     err, exp_err);
        end
    endtask

    string last_tag = "R1";

    // Check the outcome of the previous cycle, then drive the next one
    task automatic cycle(input string tag, input bit v, input logic [3:0] op,
                         input logic [1:0] sz, input int s, input logic [15:0] pm,
                         input logic [127:0] d, input logic [127:0] sv);
        logic [127:0] r;
        logic         e;
        @(negedge clk);
        check(last_tag);
        in_valid = v; op_code = op; elem_size = sz; shift_amt = 6'(s);
        pred_mask = pm; dst_vec = d; src_vec = sv;
        exp_done = v;
        if (v) begin
            ref_op(op, sz, s, pm, d, sv, r, e);
            exp_res = r;
            exp_err = e;
        end else begin
            exp_err = 1'b0;
        end
        last_tag = tag;
    endtask

    function automatic string tag_for(input logic [3:0] op, input logic [1:0] sz,
                                      input int s, input logic [15:0] pm);
        int ew;
        ew = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : (sz == 2'b10) ? 32 : 0;
        if (ew == 0 || !(op == 4'b0100 || op == 4'b0101)) return "R8";
        if (op == 4'b0101 && s >= ew) return "R8";
        if (op == 4'b0100 && (s == 0 || s > ew)) return "R8";
        if ((op == 4'b0101 && s == 0) || (op == 4'b0100 && s == ew)) return "R6";
        if (pm != 16'hFFFF) return "R7";
        if (sz != 2'b00) return "R5";
        return (op == 4'b0101) ? "R4" : "R3";
    endfunction

    localparam logic [127:0] DA = {4{32'hA5A5_5A5A}};
    localparam logic [127:0] DB = {4{32'h0F0F_F0F0}};
    localparam logic [127:0] SA = {4{32'hFFFF_FFFF}};
    localparam logic [127:0] SB = {4{32'h1234_8765}};

    initial begin
        // reset phase, R1
        repeat (3) begin
            @(negedge clk);
            check("R1");
        end
        rst_n = 1'b1;
        cycle("R1", 0, 4'h0, 2'b00, 0, 16'h0, '0, '0);
        // right insert, R3
        cycle("R3", 1, 4'b0100, 2'b00, 3, 16'hFFFF, DA, SA);
        cycle("R3", 1, 4'b0100, 2'b00, 7, 16'hFFFF, DB, SB);
        // left insert, R4
        cycle("R4", 1, 4'b0101, 2'b00, 1, 16'hFFFF, DA, SB);
        cycle("R4", 1, 4'b0101, 2'b00, 5, 16'hFFFF, DB, SA);
        // sizes and lane isolation, R5
        cycle("R5", 1, 4'b0100, 2'b01, 15, 16'hFFFF, DA, SA);
        cycle("R5", 1, 4'b0101, 2'b01, 9, 16'hFFFF, DB, SA);
        cycle("R5", 1, 4'b0100, 2'b10, 31, 16'hFFFF, '0, SA);
        cycle("R5", 1, 4'b0101, 2'b10, 17, 16'hFFFF, DA, SB);
        // edge counts, R6
        cycle("R6", 1, 4'b0100, 2'b00, 8, 16'hFFFF, DA, SA);
        cycle("R6", 1, 4'b0100, 2'b10, 32, 16'hFFFF, DB, SA);
        cycle("R6", 1, 4'b0101, 2'b01, 0, 16'hFFFF, DA, SA);
        // predicate, R7
        cycle("R7", 1, 4'b0101, 2'b10, 4, 16'h00FF, DA, SA);
        cycle("R7", 1, 4'b0100, 2'b10, 4, 16'hFF00, DB, SA);
        cycle("R7", 1, 4'b0100, 2'b01, 2, 16'h5A3C, DA, SB);
        cycle("R7", 1, 4'b0101, 2'b00, 2, 16'h0000, DA, SA);
        // errors, R8
        cycle("R8", 1, 4'b0100, 2'b11, 3, 16'hFFFF, DA, SA);
        cycle("R8", 1, 4'b0110, 2'b00, 3, 16'hFFFF, DB, SA);
        cycle("R8", 1, 4'b0100, 2'b01, 0, 16'hFFFF, DA, SA);
        cycle("R8", 1, 4'b0101, 2'b00, 8, 16'hFFFF, DB, SA);
        cycle("R8", 1, 4'b0100, 2'b00, 9, 16'hFFFF, DA, SA);
        // pulse shape and hold, R2 and R9
        cycle("R2", 0, 4'h0, 2'b00, 0, 16'h0, SA, SA);
        cycle("R2", 0, 4'h0, 2'b00, 0, 16'h0, '0, '0);
        cycle("R9", 1, 4'b0100, 2'b01, 16, 16'hFFFF, DB, SA);
        cycle("R2", 0, 4'h0, 2'b00, 0, 16'h0, '0, '0);
        cycle("R9", 1, 4'b0101, 2'b11, 1, 16'hFFFF, DA, SA);
        cycle("R2", 0, 4'h0, 2'b00, 0, 16'h0, '0, '0);
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            bit          v;
            logic [3:0]  op;
            logic [1:0]  sz;
            int          s;
            logic [15:0] pm;
            v  = ($urandom % 4) != 0;
            op = ($urandom % 8 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'b0101 : 4'b0100);
            sz = 2'($urandom % 4);
            s  = $urandom % 34;
            pm = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
            cycle(v ? tag_for(op, sz, s, pm) : "R2", v, op, sz, s, pm,
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom});
        end
        cycle("R2", 0, 4'h0, 2'b00, 0, 16'h0, '0, '0);
        @(negedge clk);
        check(last_tag);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        tests++;
        fails++;
        $display("FAIL watchdog R2 act=hung exp=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule